// File: doc/BRIEF.md
# Stop-and-Wait Parallel Link Transmitter

This block sends one fixed-size game-state packet at a time to a peer board over a synchronous link. The game logic presents an 832-bit payload and pulses `start`. The transmitter captures the payload and stripes it over four data lanes, one bit per lane per link clock. Each lane's bit stream is protected by its own Hamming(7,4) code. The peer samples every lane with a copy of `clk` forwarded beside the data. Producing that forwarded copy and driving the pads happen outside this block.

After the last codeword, the transmitter listens on a single return handshake wire. Every message on that wire is one start bit followed by three copies of a response bit. The response is decided by majority vote, so one corrupted copy is tolerated. An acknowledge frees the transmitter for the next packet. A negative acknowledge, or silence that lasts for a programmable number of link clocks, makes it send the same packet again.

The control machine has four states:
- IDLE: waiting for work. `start` takes it to MARK.
- MARK: sends the four marker bits. After the fourth bit it goes to DATA.
- DATA: sends the 364 coded bits. After the last bit it goes to WAIT.
- WAIT: listens for a reply. It goes back to IDLE on an acknowledge. A negative acknowledge or a timeout takes it to MARK, which starts a resend.

Top module: `parlink_tx`

## Requirements
- R1: While reset is held, and right after it is released, `busy` is 0 and all lanes are 0.
- R2: A `start` pulse sampled in IDLE captures `payload` and raises `busy` on the same edge. `busy` then stays high through every cycle of the frame and of the wait, until an acknowledge is decoded.
- R3: Every frame opens with the marker 1,1,1,0, sent on all four lanes at once. The first marker cycle shows all lanes high.
- R4: Packet bit i travels on lane i mod 4. Lane bit j is `payload[4*j + lane]`. Codeword k of a lane carries lane bits 4k..4k+3, and codewords go out in ascending k, 52 of them per lane.
- R5: Each codeword is sent as d3, d2, d1, d0, p2, p1, p0, one bit per clock. Here d3..d0 are lane bits 4k+3..4k. The parity bits are p0 = d0^d1^d3, p1 = d0^d2^d3 and p2 = d1^d2^d3. A frame is 368 clocks long.
- R6: Lanes are 0 in IDLE and in WAIT.
- R7: While `busy` is high, changes on `payload` and further `start` pulses have no effect on the bits sent, including those of resends.
- R8: A handshake message is a 1 start bit followed by three response copies, each sampled on one clock. The majority of the copies decides the response: 1 is an acknowledge, 0 is a negative acknowledge. An acknowledge decoded in WAIT drops `busy` on the edge that samples the third copy.
- R9: A negative acknowledge decoded in WAIT restarts the same packet at once. The cycle after the edge that samples the third copy shows the first marker bit.
- R10: If WAIT has lasted `timeout_cycles` clocks with no decoded message, the same packet is resent. A `timeout_cycles` of 0 behaves as 1.
- R11: Handshake messages decoded while the transmitter is in IDLE are ignored: `busy` stays 0 and the lanes stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock; one bit per lane per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send `payload`; honoured only in IDLE |
| payload | input | PAYLOAD_W (832) | Packet to send |
| timeout_cycles | input | TO_W (16) | Length of the wait for a reply, in clocks |
| hs_in | input | 1 | Return handshake wire from the peer |
| lane_out | output | LANES (4) | Serial data lanes |
| busy | output | 1 | High from the accepted start until an acknowledge |

## Verification
Some rules are checked by the embedded properties on every cycle:
- lanes stay silent outside a frame;
- the first cycle of each frame shows all ones;
- the captured payload does not move while the transmitter is busy;
- the wait counter stays within its limit;
- an acknowledge releases `busy` and a negative acknowledge restarts the frame.

Other behaviour can only be shown by the bench's scenarios, which compare each lane bit with a model of the frame:
- the bit-exact mapping and code of all 368 bits of a frame, for several payloads;
- that a resend repeats the original packet even after the payload input has changed;
- majority voting when one response copy is corrupted;
- the exact cycle on which a timeout fires, including the zero setting.

// File: rtl/parlink_pkg.sv
package parlink_pkg;

    localparam logic [3:0] FRAME_MARKER = 4'b1110;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_DATA,
        ST_WAIT
    } tx_state_e;

    typedef enum logic {
        HS_IDLE,
        HS_BITS
    } hs_state_e;

    // Codeword layout {d3,d2,d1,d0,p2,p1,p0}
    function automatic logic [6:0] ham74_encode(input logic [3:0] d);
        logic p0, p1, p2;
        p0 = d[0] ^ d[1] ^ d[3];
        p1 = d[0] ^ d[2] ^ d[3];
        p2 = d[1] ^ d[2] ^ d[3];
        return {d, p2, p1, p0};
    endfunction

endpackage

// File: rtl/parlink_lane.sv
module parlink_lane
    import parlink_pkg::*;
#(
    parameter int LANE_W = 208,
    parameter int CW_W   = 6
) (
    input  logic [LANE_W-1:0] slice,
    input  logic              in_mark,
    input  logic              in_data,
    input  logic [1:0]        mark_idx,
    input  logic [CW_W-1:0]   cw_idx,
    input  logic [2:0]        pos,
    output logic              bit_out
);
    localparam int IDX_W = $clog2(LANE_W);

    logic [IDX_W-1:0] base;
    logic [3:0]       nibble;
    logic [6:0]       cw;

    assign base   = IDX_W'({cw_idx, 2'b00});
    assign nibble = slice[base +: 4];
    assign cw     = ham74_encode(nibble);

    always_comb begin
        if (in_mark)
            bit_out = FRAME_MARKER[2'd3 - mark_idx];
        else if (in_data)
            bit_out = cw[3'd6 - pos];
        else
            bit_out = 1'b0;
    end

endmodule

// File: rtl/parlink_hs_rx.sv
module parlink_hs_rx
    import parlink_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_in,
    output logic msg_valid,
    output logic msg_ack
);
    hs_state_e  st;
    logic [1:0] cnt;
    logic [1:0] copies;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= HS_IDLE;
            cnt    <= 2'd0;
            copies <= 2'd0;
        end else begin
            unique case (st)
                HS_IDLE: begin
                    cnt <= 2'd0;
                    if (hs_in) st <= HS_BITS;
                end
                HS_BITS: begin
                    copies <= {copies[0], hs_in};
                    cnt    <= cnt + 2'd1;
                    if (cnt == 2'd2) st <= HS_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        msg_valid = (st == HS_BITS) && (cnt == 2'd2);
        msg_ack   = (copies[1] & copies[0]) | (copies[1] & hs_in) | (copies[0] & hs_in);
    end

    // R8: a message is at least four clocks long, so decodes never come back to back
    assert_single_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

endmodule

// File: rtl/parlink_tx.sv
module parlink_tx
    import parlink_pkg::*;
#(
    parameter int PAYLOAD_W = 832,
    parameter int LANES     = 4,
    parameter int TO_W      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic [TO_W-1:0]      timeout_cycles,
    input  logic                 hs_in,
    output logic [LANES-1:0]     lane_out,
    output logic                 busy
);
    localparam int LANE_W = PAYLOAD_W / LANES;
    localparam int CW_N   = LANE_W / 4;
    localparam int CW_W   = $clog2(CW_N);

    tx_state_e              state, state_nx;
    logic [PAYLOAD_W-1:0]   pay_q;
    logic [1:0]             mark_idx;
    logic [CW_W-1:0]        cw_idx;
    logic [2:0]             pos;
    logic [TO_W-1:0]        wait_cnt;
    logic                   in_mark, in_data;
    logic                   hs_valid, hs_ack;
    logic                   last_bit, timeout_hit;

    assign last_bit    = (cw_idx == CW_W'(CW_N - 1)) && (pos == 3'd6);
    assign timeout_hit = ({1'b0, wait_cnt} + (TO_W+1)'(1)) >= {1'b0, timeout_cycles};

    parlink_hs_rx u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_in     (hs_in),
        .msg_valid (hs_valid),
        .msg_ack   (hs_ack)
    );

    // State register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pay_q    <= '0;
            mark_idx <= 2'd0;
            cw_idx   <= '0;
            pos      <= 3'd0;
            wait_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) pay_q <= payload;
            mark_idx <= (state == ST_MARK) ? mark_idx + 2'd1 : 2'd0;
            if (state == ST_DATA) begin
                if (pos == 3'd6) begin
                    pos    <= 3'd0;
                    cw_idx <= cw_idx + CW_W'(1);
                end else begin
                    pos <= pos + 3'd1;
                end
            end else begin
                pos    <= 3'd0;
                cw_idx <= '0;
            end
            wait_cnt <= (state == ST_WAIT) ? wait_cnt + TO_W'(1) : '0;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_MARK;
            ST_MARK: if (mark_idx == 2'd3) state_nx = ST_DATA;
            ST_DATA: if (last_bit) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (hs_valid && hs_ack)  state_nx = ST_IDLE;
                else if (hs_valid)       state_nx = ST_MARK;
                else if (timeout_hit)    state_nx = ST_MARK;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy    = 1'b1;
        in_mark = 1'b0;
        in_data = 1'b0;
        unique case (state)
            ST_IDLE: busy    = 1'b0;
            ST_MARK: in_mark = 1'b1;
            ST_DATA: in_data = 1'b1;
            ST_WAIT: ;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] slice;
        for (genvar j = 0; j < LANE_W; j++) begin : g_bit
            assign slice[j] = pay_q[j*LANES + l];
        end
        parlink_lane #(.LANE_W(LANE_W), .CW_W(CW_W)) u_lane (
            .slice    (slice),
            .in_mark  (in_mark),
            .in_data  (in_data),
            .mark_idx (mark_idx),
            .cw_idx   (cw_idx),
            .pos      (pos),
            .bit_out  (lane_out[l])
        );
    end

    assert_quiet_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT) |-> (lane_out == '0));

    assert_marker_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (lane_out == '1));

    assert_payload_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pay_q));

    assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && hs_valid && hs_ack) |=> !busy);

    assert_nak_resend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && hs_valid && !hs_ack) |=> (busy && lane_out == '1));

    assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> ((wait_cnt < timeout_cycles) || (wait_cnt == '0)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> !busy);

endmodule

// File: tb/sim_parlink_tx.sv
module sim_parlink_tx;
    localparam int CLK_PERIOD = 10;
    localparam int PW    = 832;
    localparam int LN    = 4;
    localparam int TOW   = 16;
    localparam int TO    = 16;
    localparam int FRAME = 4 + 7 * (PW / LN / 4);
    localparam int NVEC  = 6;
    // {kind[3:0], seed[31:0]}; kind 0 ack, 1 ack with a bad copy, 2 nak, 3 nak with a bad copy, 4 timeout
    localparam logic [35:0] VEC [0:NVEC-1] = '{
        36'h0_00000000, 36'h0_FFFFFFFF, 36'h1_12345678,
        36'h2_0BADF00D, 36'h3_5A5A1234, 36'h4_00C0FFEE
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic [PW-1:0]  payload;
    logic [TOW-1:0] timeout;
    logic           hs_in;
    logic [LN-1:0]  lane_out;
    logic           busy;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [PW-1:0] p;
    logic [3:0]    kind;

    always #(CLK_PERIOD/2) clk = ~clk;

    parlink_tx #(.PAYLOAD_W(PW), .LANES(LN), .TO_W(TOW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .payload(payload),
        .timeout_cycles(timeout), .hs_in(hs_in), .lane_out(lane_out), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] mk_payload(input logic [31:0] s);
        logic [PW-1:0] r;
        logic [31:0]   w;
        if (s == 32'h0) return '0;
        if (s == 32'hFFFFFFFF) return '1;
        w = s;
        for (int i = 0; i < PW/32; i++) begin
            w = w ^ (w << 13);
            w = w ^ (w >> 17);
            w = w ^ (w << 5);
            r[i*32 +: 32] = w;
        end
        return r;
    endfunction

    // Expected lane bit at frame position idx (R3, R4, R5)
    function automatic logic exp_bit(input logic [PW-1:0] pk, input int lane, input int idx);
        int j, k, q;
        logic a, b, c, d;
        if (idx < 4) return (idx != 3);
        j = idx - 4;
        k = j / 7;
        q = j % 7;
        a = pk[(4*k+3)*LN + lane];
        b = pk[(4*k+2)*LN + lane];
        c = pk[(4*k+1)*LN + lane];
        d = pk[(4*k)*LN + lane];
        case (q)
            0: return a;
            1: return b;
            2: return c;
            3: return d;
            4: return c ^ b ^ a;
            5: return d ^ b ^ a;
            default: return d ^ c ^ a;
        endcase
    endfunction

    // Starts at the negedge showing frame bit 0, ends at the first WAIT negedge
    task automatic capture(input logic [PW-1:0] pk);
        int bad = 0;
        int busy_bad = 0;
        logic [3:0] e;
        logic [3:0] fa = '0;
        logic [3:0] fe = '0;
        for (int idx = 0; idx < FRAME; idx++) begin
            if (idx == 100) start = 1'b1;
            if (idx == 101) start = 1'b0;
            for (int l = 0; l < LN; l++) e[l] = exp_bit(pk, l, idx);
            if (lane_out !== e) begin
                if (bad == 0) begin fa = lane_out; fe = e; end
                bad++;
            end
            if (busy !== 1'b1) busy_bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R3 R4 R5 R7 frame bits", fa, fe);
        chk(busy_bad == 0, "R2 busy through frame", busy_bad, 0);
    endtask

    task automatic hs_send(input logic c1, input logic c2, input logic c3);
        hs_in = 1'b1;
        @(negedge clk); hs_in = c1;
        @(negedge clk); hs_in = c2;
        @(negedge clk); hs_in = c3;
        @(negedge clk); hs_in = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; payload = '0; hs_in = 1'b0; timeout = TOW'(TO);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && lane_out === '0, "R1 during reset", {busy, lane_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && lane_out === '0, "R1 after release", {busy, lane_out}, 0);

        for (int v = 0; v < NVEC; v++) begin
            p = mk_payload(VEC[v][31:0]);
            kind = VEC[v][35:32];
            payload = p; start = 1'b1;
            @(negedge clk);
            start = 1'b0; payload = ~p;
            chk(busy === 1'b1, "R2 busy after start", busy, 1);
            capture(p);
            case (kind)
                4'd0: hs_send(1'b1, 1'b1, 1'b1);
                4'd1: hs_send(1'b1, 1'b0, 1'b1);
                4'd2, 4'd3: begin
                    if (kind == 4'd2) hs_send(1'b0, 1'b0, 1'b0);
                    else              hs_send(1'b0, 1'b1, 1'b0);
                    chk(lane_out === 4'hF && busy === 1'b1, "R9 resend after nak", lane_out, 4'hF);
                    capture(p);
                    hs_send(1'b1, 1'b1, 1'b1);
                end
                default: begin
                    int quiet_bad = 0;
                    for (int c = 0; c < TO; c++) begin
                        if (lane_out !== '0 || busy !== 1'b1) quiet_bad++;
                        @(negedge clk);
                    end
                    chk(quiet_bad == 0, "R6 R10 quiet wait", quiet_bad, 0);
                    chk(lane_out === 4'hF, "R10 resend after timeout", lane_out, 4'hF);
                    capture(p);
                    hs_send(1'b1, 1'b1, 1'b1);
                end
            endcase
            chk(busy === 1'b0 && lane_out === '0, "R8 ack releases", {busy, lane_out}, 0);
            repeat (2) @(negedge clk);
        end

        // R11: replies while idle have no effect
        begin
            int idle_bad = 0;
            hs_send(1'b1, 1'b1, 1'b1);
            if (busy !== 1'b0 || lane_out !== '0) idle_bad++;
            hs_send(1'b0, 1'b0, 1'b0);
            for (int c = 0; c < 6; c++) begin
                if (busy !== 1'b0 || lane_out !== '0) idle_bad++;
                @(negedge clk);
            end
            chk(idle_bad == 0, "R11 idle handshake ignored", idle_bad, 0);
        end

        // R10: zero timeout behaves as one clock
        timeout = '0;
        p = mk_payload(32'h13572468);
        payload = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0; payload = '0;
        capture(p);
        chk(lane_out === '0 && busy === 1'b1, "R10 zero timeout one quiet cycle", lane_out, 0);
        @(negedge clk);
        chk(lane_out === 4'hF, "R10 zero timeout resend", lane_out, 4'hF);
        timeout = TOW'(TO);
        capture(p);
        hs_send(1'b1, 1'b1, 1'b1);
        chk(busy === 1'b0, "R8 final ack", busy, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule